// File: doc/BRIEF.md
# DMA Transfer Unit Sequencer

This block is the control counter of one DMA channel. Work is organised in nested units: a fragment is a run of beats, a block is a run of whole fragments, a transaction is a run of whole blocks, and a list is a run of whole transactions. All three lengths are programmed in beats; the list length is programmed in transactions. The sequencer does not move data. It asks for beats on a strobe and counts the ones that are acknowledged. It marks every unit boundary with a one-cycle done pulse. It also raises a sticky interrupt for the boundary kinds that the selected interrupt type covers.

A start pulse, given while the channel is idle, latches the configuration and checks it. If the configuration is bad, the channel stays idle and raises the interrupt. If it is good, the channel waits for a peripheral request. Each request authorises exactly one unit of the kind named by the request mode. When that unit is done, the channel stops requesting beats and waits for the next request. The channel returns to idle after one transaction, or after the whole list in linked-list mode.

The beat interface works like a valid/ready pair. `beat_req_o` is the valid side and `beat_ack_i` is the ready side. A beat completes in a cycle where both are high. While the acknowledge stays low, the strobe holds and no counter moves, so the consumer can apply back-pressure for as long as it needs.

Top module: `dma_unit_sequencer`

## Requirements
- R1: After reset, `beat_req_o`, `busy_o`, `irq_o` and all four done pulses are low.
- R2: A start with any of these conditions leaves the channel idle and sets the interrupt status, whatever the interrupt type: a fragment, block or transaction length of zero; a block length that is not a multiple of the fragment length; a transaction length that is not a multiple of the block length; or linked-list mode with a list count of zero.
- R3: A beat completes only in a cycle where `beat_req_o` and `beat_ack_i` are both high. While `beat_ack_i` is low, `beat_req_o` stays high and no done pulse fires.
- R4: Request mode code 0 is fragment, 1 is block, 2 is transaction and 3 is linked-list. One request authorises exactly one unit of that kind. After the unit, `beat_req_o` drops until the next request.
- R5: A request that arrives while a unit is in progress is ignored. It does not count towards any later unit.
- R6: `frag_done_o`, `blk_done_o` and `xfer_done_o` each pulse for one cycle, in the cycle after the handshake of the final beat of their unit. Pulses for units that end on the same beat fire together.
- R7: In modes 0 to 2 the channel goes idle after one transaction, and `list_done_o` stays low. In mode 3 the channel runs the programmed count of transactions, pulses `list_done_o` once, and then goes idle.
- R8: The interrupt type code selects which events set the interrupt: 0 none, 1 fragment, 2 block, 3 block or fragment, 4 transaction, 5 transaction or fragment, 6 transaction or block, 7 list, 8 configuration error only. Codes 9 to 15 select no done event.
- R9: The interrupt status stays set until `irq_clr_i` is high for a cycle. If a new event and a clear fall in the same cycle, the event wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Latch and check the configuration; only acted on while idle |
| req_mode_i | input | 2 | Unit authorised by one request (0 fragment, 1 block, 2 transaction, 3 list) |
| irq_type_i | input | 4 | Interrupt event selection code |
| frag_len_i | input | LEN_W | Beats per fragment |
| blk_len_i | input | LEN_W | Beats per block |
| xfer_len_i | input | LEN_W | Beats per transaction |
| list_cnt_i | input | LIST_W | Transactions per list (linked-list mode) |
| per_req_i | input | 1 | Peripheral request strobe |
| beat_req_o | output | 1 | Beat request (valid side of the beat handshake) |
| beat_ack_i | input | 1 | Beat acknowledge (ready side of the beat handshake) |
| frag_done_o | output | 1 | Fragment completed pulse |
| blk_done_o | output | 1 | Block completed pulse |
| xfer_done_o | output | 1 | Transaction completed pulse |
| list_done_o | output | 1 | List completed pulse |
| busy_o | output | 1 | Channel is not idle |
| irq_o | output | 1 | Sticky interrupt status |
| irq_clr_i | input | 1 | Write-one-to-clear for the interrupt status |

## Verification
The assertions assume that the inputs are free of X/Z after reset. They also assume that the configuration inputs matter only in the cycle of an accepted start, because the block latches them there.

The checks on nesting and range are only meaningful for a configuration that passed the divisibility checks. The bench therefore starts a run only with valid tables, or with deliberately bad ones that must be rejected.

The bench drives every input on the falling edge. It raises a request only while the channel is waiting. Any extra request it sends while the channel is running is exactly the traffic that R5 says to ignore.

// File: rtl/dmaseq_pkg.sv
package dmaseq_pkg;

  typedef enum logic [1:0] {
    RQ_FRAG  = 2'd0,
    RQ_BLOCK = 2'd1,
    RQ_XFER  = 2'd2,
    RQ_LIST  = 2'd3
  } req_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_RUN  = 2'd2
  } seq_state_e;

  // Bit order of the event vector: {list, xfer, block, frag}
  localparam int EV_N = 4;

  function automatic logic [EV_N-1:0] irq_event_mask(input logic [3:0] code);
    logic [EV_N-1:0] m;
    case (code)
      4'd1:    m = 4'b0001;
      4'd2:    m = 4'b0010;
      4'd3:    m = 4'b0011;
      4'd4:    m = 4'b0100;
      4'd5:    m = 4'b0101;
      4'd6:    m = 4'b0110;
      4'd7:    m = 4'b1000;
      default: m = 4'b0000;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/dmaseq_cfg_check.sv
module dmaseq_cfg_check #(
  parameter int LEN_W  = 16,
  parameter int LIST_W = 8
) (
  input  logic [1:0]        mode_i,
  input  logic [LEN_W-1:0]  frag_len_i,
  input  logic [LEN_W-1:0]  blk_len_i,
  input  logic [LEN_W-1:0]  xfer_len_i,
  input  logic [LIST_W-1:0] list_cnt_i,
  output logic              ok_o
);
  import dmaseq_pkg::*;

  logic [LEN_W-1:0] frag_div, blk_div;
  logic             any_zero, blk_misfit, xfer_misfit, list_bad;

  always_comb begin
    frag_div    = (frag_len_i == '0) ? LEN_W'(1) : frag_len_i;
    blk_div     = (blk_len_i  == '0) ? LEN_W'(1) : blk_len_i;
    any_zero    = (frag_len_i == '0) || (blk_len_i == '0) || (xfer_len_i == '0);
    blk_misfit  = (blk_len_i  % frag_div) != '0;
    xfer_misfit = (xfer_len_i % blk_div)  != '0;
    list_bad    = (req_mode_e'(mode_i) == RQ_LIST) && (list_cnt_i == '0);
    ok_o        = !(any_zero || blk_misfit || xfer_misfit || list_bad);
  end

endmodule

// File: rtl/dmaseq_counter.sv
module dmaseq_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         inc_i,
  input  logic [W-1:0] limit_i,
  output logic         last_o
);
  logic [W-1:0] cnt_q;

  assign last_o = inc_i && (cnt_q == limit_i - W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (inc_i)  cnt_q <= last_o ? '0 : cnt_q + W'(1);
  end

  // R6: the position inside a unit never reaches the unit length
  assert_count_in_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (limit_i != '0) |-> (cnt_q < limit_i));

endmodule

// File: rtl/dmaseq_irq.sv
module dmaseq_irq (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] type_i,
  input  logic [3:0] ev_i,
  input  logic       cfgerr_i,
  input  logic       clr_i,
  output logic       irq_o
);
  import dmaseq_pkg::*;

  logic irq_q, hit;

  assign hit   = cfgerr_i || ((irq_event_mask(type_i) & ev_i) != '0);
  assign irq_o = irq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     irq_q <= 1'b0;
    else if (hit)   irq_q <= 1'b1;
    else if (clr_i) irq_q <= 1'b0;
  end

  assert_irq_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_q && !clr_i) |=> irq_q);
  assert_irq_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !cfgerr_i && ev_i == '0) |=> !irq_q);
  assert_cfgerr_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cfgerr_i |=> irq_q);

endmodule

// File: rtl/dma_unit_sequencer.sv
module dma_unit_sequencer #(
  parameter int LEN_W  = 16,
  parameter int LIST_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [1:0]        req_mode_i,
  input  logic [3:0]        irq_type_i,
  input  logic [LEN_W-1:0]  frag_len_i,
  input  logic [LEN_W-1:0]  blk_len_i,
  input  logic [LEN_W-1:0]  xfer_len_i,
  input  logic [LIST_W-1:0] list_cnt_i,
  input  logic              per_req_i,
  output logic              beat_req_o,
  input  logic              beat_ack_i,
  output logic              frag_done_o,
  output logic              blk_done_o,
  output logic              xfer_done_o,
  output logic              list_done_o,
  output logic              busy_o,
  output logic              irq_o,
  input  logic              irq_clr_i
);
  import dmaseq_pkg::*;

  localparam int LVL_N = 3; // beat-counted levels: fragment, block, transaction

  seq_state_e       state_q, state_d;
  req_mode_e        mode_q;
  logic [3:0]       type_q;
  logic [LEN_W-1:0] lim [LVL_N];
  logic [LIST_W-1:0] list_q;
  logic [LVL_N-1:0] lvl_last;
  logic             list_last;

  logic cfg_ok, start_ok, cfg_bad, beat, unit_end, chan_end;
  logic [EV_N-1:0] ev, ev_q;

  dmaseq_cfg_check #(.LEN_W(LEN_W), .LIST_W(LIST_W)) u_check (
    .mode_i     (req_mode_i),
    .frag_len_i (frag_len_i),
    .blk_len_i  (blk_len_i),
    .xfer_len_i (xfer_len_i),
    .list_cnt_i (list_cnt_i),
    .ok_o       (cfg_ok)
  );

  assign start_ok = start_i && (state_q == ST_IDLE) && cfg_ok;
  assign cfg_bad  = start_i && (state_q == ST_IDLE) && !cfg_ok;
  assign beat     = (state_q == ST_RUN) && beat_ack_i;

  genvar g;
  generate
    for (g = 0; g < LVL_N; g++) begin : g_lvl
      dmaseq_counter #(.W(LEN_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (start_ok),
        .inc_i   (beat),
        .limit_i (lim[g]),
        .last_o  (lvl_last[g])
      );
    end
  endgenerate

  dmaseq_counter #(.W(LIST_W)) u_list_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_i   (start_ok),
    .inc_i   (lvl_last[2]),
    .limit_i (list_q),
    .last_o  (list_last)
  );

  always_comb begin
    ev[0] = lvl_last[0];
    ev[1] = lvl_last[1];
    ev[2] = lvl_last[2];
    ev[3] = list_last && (mode_q == RQ_LIST);
    case (mode_q)
      RQ_FRAG:  unit_end = ev[0];
      RQ_BLOCK: unit_end = ev[1];
      RQ_XFER:  unit_end = ev[2];
      default:  unit_end = ev[3];
    endcase
    chan_end = (mode_q == RQ_LIST) ? ev[3] : ev[2];
  end

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (start_ok) state_d = ST_WAIT;
      ST_WAIT: if (per_req_i) state_d = ST_RUN;
      ST_RUN: begin
        if (beat) begin
          if (chan_end)      state_d = ST_IDLE;
          else if (unit_end) state_d = ST_WAIT;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      mode_q  <= RQ_FRAG;
      type_q  <= '0;
      lim[0]  <= '0;
      lim[1]  <= '0;
      lim[2]  <= '0;
      list_q  <= '0;
      ev_q    <= '0;
    end else begin
      state_q <= state_d;
      ev_q    <= ev;
      if (start_ok) begin
        mode_q <= req_mode_e'(req_mode_i);
        type_q <= irq_type_i;
        lim[0] <= frag_len_i;
        lim[1] <= blk_len_i;
        lim[2] <= xfer_len_i;
        list_q <= list_cnt_i;
      end
    end
  end

  dmaseq_irq u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .type_i   (type_q),
    .ev_i     (ev),
    .cfgerr_i (cfg_bad),
    .clr_i    (irq_clr_i),
    .irq_o    (irq_o)
  );

  assign beat_req_o  = (state_q == ST_RUN);
  assign busy_o      = (state_q != ST_IDLE);
  assign frag_done_o = ev_q[0];
  assign blk_done_o  = ev_q[1];
  assign xfer_done_o = ev_q[2];
  assign list_done_o = ev_q[3];

  assert_blk_has_frag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    blk_done_o |-> frag_done_o);
  assert_xfer_has_blk_R6: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done_o |-> blk_done_o);
  assert_hold_on_stall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_req_o && !beat_ack_i) |=> (beat_req_o && !frag_done_o));
  assert_bad_cfg_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o && !cfg_ok) |=> (!busy_o && irq_o));
  assert_frag_unit_waits_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (frag_done_o && mode_q == RQ_FRAG) |-> !beat_req_o);
  assert_list_only_in_list_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (list_done_o) |-> (mode_q == RQ_LIST && !busy_o));

endmodule

// File: tb/test_dma_unit_sequencer.sv
module test_dma_unit_sequencer;

  localparam int LEN_W  = 16;
  localparam int LIST_W = 8;
  localparam int NV = 12;
  // mode, irq type, frag, block, xfer, list, stall, spam
  localparam int VEC [NV][8] = '{
    '{0, 1, 2, 4, 8,  1, 0, 0},
    '{1, 2, 2, 4, 8,  1, 1, 1},
    '{2, 4, 3, 6, 12, 1, 0, 1},
    '{3, 7, 2, 2, 4,  3, 0, 0},
    '{0, 0, 1, 1, 1,  1, 0, 0},
    '{1, 3, 1, 3, 6,  1, 1, 0},
    '{2, 5, 4, 4, 4,  1, 0, 0},
    '{2, 6, 2, 4, 8,  1, 1, 1},
    '{2, 7, 2, 4, 8,  1, 0, 0},
    '{3, 8, 2, 2, 2,  2, 0, 1},
    '{2, 15, 1, 2, 4, 1, 0, 0},
    '{3, 4, 1, 2, 4,  2, 1, 1}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic [1:0] req_mode_i = '0;
  logic [3:0] irq_type_i = '0;
  logic [LEN_W-1:0] frag_len_i = '0, blk_len_i = '0, xfer_len_i = '0;
  logic [LIST_W-1:0] list_cnt_i = '0;
  logic per_req_i = 1'b0, beat_ack_i = 1'b0, irq_clr_i = 1'b0;
  logic beat_req_o, frag_done_o, blk_done_o, xfer_done_o, list_done_o, busy_o, irq_o;

  int errors = 0;
  int checks = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  dma_unit_sequencer #(.LEN_W(LEN_W), .LIST_W(LIST_W)) i_dma_unit_sequencer (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .req_mode_i(req_mode_i),
    .irq_type_i(irq_type_i), .frag_len_i(frag_len_i), .blk_len_i(blk_len_i),
    .xfer_len_i(xfer_len_i), .list_cnt_i(list_cnt_i), .per_req_i(per_req_i),
    .beat_req_o(beat_req_o), .beat_ack_i(beat_ack_i), .frag_done_o(frag_done_o),
    .blk_done_o(blk_done_o), .xfer_done_o(xfer_done_o), .list_done_o(list_done_o),
    .busy_o(busy_o), .irq_o(irq_o), .irq_clr_i(irq_clr_i)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 150000);
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  task automatic do_start(input int m, input int t, input int f, input int b,
                          input int x, input int l);
    @(negedge clk);
    req_mode_i = 2'(m); irq_type_i = 4'(t);
    frag_len_i = LEN_W'(f); blk_len_i = LEN_W'(b); xfer_len_i = LEN_W'(x);
    list_cnt_i = LIST_W'(l);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic clear_irq();
    irq_clr_i = 1'b1;
    @(negedge clk);
    irq_clr_i = 1'b0;
  endtask

  function automatic int exp_irq(input int t, input int listm);
    case (t)
      1, 2, 3, 4, 5, 6: return 1;
      7: return listm;
      default: return 0;
    endcase
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 beat_req", int'(beat_req_o), 0);
    check("R1 busy", int'(busy_o), 0);
    check("R1 irq", int'(irq_o), 0);
    check("R1 done pulses", int'({frag_done_o, blk_done_o, xfer_done_o, list_done_o}), 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      int m, t, f, b, x, l, st, sp;
      int beats, reqs, nf, nb, nx, nl, coinc, k, ebeats, ereqs;
      m = VEC[v][0]; t = VEC[v][1]; f = VEC[v][2]; b = VEC[v][3];
      x = VEC[v][4]; l = VEC[v][5]; st = VEC[v][6]; sp = VEC[v][7];
      beats = 0; reqs = 0; nf = 0; nb = 0; nx = 0; nl = 0; coinc = 0; k = 0;
      ebeats = x * ((m == 3) ? l : 1);
      case (m)
        0: ereqs = ebeats / f;
        1: ereqs = ebeats / b;
        default: ereqs = 1;
      endcase
      do_start(m, t, f, b, x, l);
      while (busy_o && k < 4000) begin
        per_req_i = 1'b0;
        beat_ack_i = 1'b0;
        if (!beat_req_o) begin
          per_req_i = 1'b1;
          reqs++;
        end else begin
          beat_ack_i = (st != 0) ? k[0] : 1'b1;
          if (beat_ack_i) beats++;
          if (sp != 0) per_req_i = ~k[0];
        end
        k++;
        @(negedge clk);
        nf += int'(frag_done_o); nb += int'(blk_done_o);
        nx += int'(xfer_done_o); nl += int'(list_done_o);
        if (frag_done_o && blk_done_o && xfer_done_o) coinc++;
      end
      per_req_i = 1'b0; beat_ack_i = 1'b0;
      check("R3 beats handshaken", beats, ebeats);
      check("R4 R5 requests needed", reqs, ereqs);
      check("R6 fragment pulses", nf, ebeats / f);
      check("R6 block pulses", nb, ebeats / b);
      check("R6 xfer pulses", nx, ebeats / x);
      check("R6 coincident pulses", coinc, ebeats / x);
      check("R7 list pulses", nl, (m == 3) ? 1 : 0);
      check("R7 idle at end", int'(busy_o), 0);
      check("R8 irq by type", int'(irq_o), exp_irq(t, (m == 3) ? 1 : 0));
      clear_irq();
      check("R9 irq cleared", int'(irq_o), 0);
    end

    // R2: bad configurations
    begin
      int bad [4][6] = '{
        '{2, 0, 0, 4, 8, 1},
        '{2, 0, 3, 4, 8, 1},
        '{2, 0, 2, 4, 6, 1},
        '{3, 0, 2, 4, 8, 0}
      };
      for (int i = 0; i < 4; i++) begin
        do_start(bad[i][0], bad[i][1], bad[i][2], bad[i][3], bad[i][4], bad[i][5]);
        check("R2 rejected busy", int'(busy_o), 0);
        check("R2 rejected beat_req", int'(beat_req_o), 0);
        check("R2 cfg error irq", int'(irq_o), 1);
        clear_irq();
        check("R9 clear after cfg error", int'(irq_o), 0);
      end
    end

    // R9: event and clear in the same cycle, event wins
    @(negedge clk);
    req_mode_i = 2'd2; frag_len_i = 0; blk_len_i = 4; xfer_len_i = 8;
    start_i = 1'b1; irq_clr_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0; irq_clr_i = 1'b0;
    check("R9 set wins over clear", int'(irq_o), 1);
    check("R9 sticky", int'(irq_o), 1);
    clear_irq();

    // R3: back-pressure holds the strobe; R5: request while stalled ignored
    do_start(2, 1, 2, 2, 2, 1);
    per_req_i = 1'b1;
    @(negedge clk);
    per_req_i = 1'b0;
    for (int i = 0; i < 5; i++) begin
      per_req_i = 1'b1;
      @(negedge clk);
      check("R3 strobe held under stall", int'(beat_req_o), 1);
      check("R3 no pulse under stall", int'(frag_done_o), 0);
    end
    per_req_i = 1'b0;
    beat_ack_i = 1'b1;
    @(negedge clk);
    @(negedge clk);
    beat_ack_i = 1'b0;
    check("R6 pulses after final beat", int'({frag_done_o, blk_done_o, xfer_done_o}), 7);
    check("R7 idle after xfer", int'(busy_o), 0);
    check("R8 fragment irq", int'(irq_o), 1);
    clear_irq();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule